// File: doc/BRIEF.md
# Floppy Drive Control Latch

This block is the address decoder and drive-control latch of a floppy-disc interface card that sits in one page of an 8-bit host expansion bus. Four consecutive page offsets (F8h to FBh) are passed straight through to an external floppy controller as a chip select. Reads and writes both pass through, because the controller's own register file lives behind that window. A write to offset FCh captures a control byte. That byte chooses the drive, the disc side and the recording density, and it also holds an enable for interrupt requests.

The controller's data-request line is gated by the latched enable bit into a host non-maskable interrupt. The host can then service every transferred byte from its interrupt routine. The gate is combinational, so the interrupt follows the request line without delay.

Drive selection is one-hot with a fixed priority: when the host sets both drive bits, the higher-numbered drive is chosen. The side bit is steered only to the drive that is actually selected.

Top module: `floppy_ctrl_latch`

## Requirements
- R1: `fdc_cs` is high in the same cycle, for reads and for writes, exactly when `bus_en` is high and `bus_addr` is F8h, F9h, FAh or FBh. It is low for every other offset, including FCh.
- R2: A cycle with `bus_en`, `bus_we` and `bus_addr` = FCh loads `bus_wdata` into the control byte at that clock edge. A read of FCh, a write to any other offset, or a cycle with `bus_en` low leaves every output that the control byte drives unchanged.
- R3: Control bit 1 requests drive 0 and bit 2 requests drive 1. `drv_sel` is 2'b01 for bit 1 alone and 2'b10 for bit 2 alone. It is 2'b10 when both bits are set and 2'b00 when neither is set.
- R4: Control bit 0 is the side (0 = side 0, 1 = side 1). It appears on `drv_side[i]` only for the drive i that `drv_sel` selects. Every unselected drive sees 0.
- R5: Control bit 5 drives `single_den` (0 = double density, 1 = single density).
- R6: `host_nmi` is high exactly when `fdc_drq` is high and control bit 4 is 1. It is combinational, so it falls in the same cycle that `fdc_drq` falls.
- R7: Control bits 3, 6 and 7 are stored but change no output. Writing C8h gives the same outputs as writing 00h.
- R8: A synchronous active-high `rst` clears the control byte. After reset, `drv_sel` = 00, `drv_side` = 00 and `single_den` = 0, and `host_nmi` stays low even while `fdc_drq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Card page is being accessed this cycle |
| bus_addr | input | 8 | Offset within the page |
| bus_we | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | input | 8 | Write data |
| fdc_drq | input | 1 | Data request from the floppy controller |
| fdc_cs | output | 1 | Chip select to the floppy controller |
| drv_sel | output | 2 | One-hot drive select (bit i = drive i) |
| drv_side | output | 2 | Side select for each drive, only on the selected one |
| single_den | output | 1 | 1 = single density, 0 = double density |
| host_nmi | output | 1 | Non-maskable interrupt request to the host |

## Verification
`fdc_cs` and `host_nmi` are combinational, so they are sampled one time unit after the inputs are driven at the falling edge, with no clock edge in between. The drive, side and density outputs come from the control register. They take their new value at the rising edge on which the FCh write is presented, so the bench samples them at the falling edge that follows. Ignored accesses (reads of FCh, writes to other offsets, cycles with the page not enabled) are checked the same way: the outputs are sampled half a cycle after the edge and must match what they were before.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam int unsigned BUS_AW   = 8;
    localparam int unsigned BUS_DW   = 8;
    localparam int unsigned N_DRIVES = 2;

    localparam logic [BUS_AW-1:0] FDC_WIN_BASE = 8'hF8;
    localparam int unsigned       FDC_WIN_BITS = 2;   // window of 4 offsets
    localparam logic [BUS_AW-1:0] CTRL_OFFSET  = 8'hFC;

    // control byte layout, MSB first
    typedef struct packed {
        logic [1:0] spare_hi;    // bits 7:6, stored only
        logic       single_den;  // bit 5
        logic       nmi_en;      // bit 4
        logic       spare_mid;   // bit 3, stored only
        logic [N_DRIVES-1:0] drv_req; // bits 2:1
        logic       side;        // bit 0
    } ctrl_t;

    function automatic logic in_fdc_window(input logic [BUS_AW-1:0] a);
        return a[BUS_AW-1:FDC_WIN_BITS] == FDC_WIN_BASE[BUS_AW-1:FDC_WIN_BITS];
    endfunction

endpackage

// File: rtl/flc_addr_dec.sv
module flc_addr_dec
    import flc_pkg::*;
(
    input  logic              bus_en,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    output logic              fdc_cs,
    output logic              ctrl_wr
);
    always_comb begin
        fdc_cs  = bus_en && in_fdc_window(bus_addr);
        ctrl_wr = bus_en && bus_we && (bus_addr == CTRL_OFFSET);
    end
endmodule

// File: rtl/flc_ctrl_reg.sv
module flc_ctrl_reg
    import flc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [BUS_DW-1:0] din,
    output ctrl_t             ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ld)
            ctrl_q <= ctrl_t'(din);
    end
endmodule

// File: rtl/flc_drive_sel.sv
module flc_drive_sel
    import flc_pkg::*;
(
    input  ctrl_t               ctrl,
    output logic [N_DRIVES-1:0] drv_sel,
    output logic [N_DRIVES-1:0] drv_side
);
    // highest-numbered requested drive wins
    for (genvar i = 0; i < N_DRIVES; i++) begin : g_drv
        if (i == N_DRIVES - 1) begin : g_top
            assign drv_sel[i] = ctrl.drv_req[i];
        end else begin : g_low
            assign drv_sel[i] = ctrl.drv_req[i] && !(|ctrl.drv_req[N_DRIVES-1:i+1]);
        end
        assign drv_side[i] = drv_sel[i] && ctrl.side;
    end
endmodule

// File: rtl/floppy_ctrl_latch.sv
module floppy_ctrl_latch
    import flc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BUS_DW-1:0]   bus_wdata,
    input  logic                fdc_drq,
    output logic                fdc_cs,
    output logic [N_DRIVES-1:0] drv_sel,
    output logic [N_DRIVES-1:0] drv_side,
    output logic                single_den,
    output logic                host_nmi
);
    logic  ctrl_wr;
    ctrl_t ctrl_q;

    flc_addr_dec u_dec (
        .bus_en  (bus_en),
        .bus_addr(bus_addr),
        .bus_we  (bus_we),
        .fdc_cs  (fdc_cs),
        .ctrl_wr (ctrl_wr)
    );

    flc_ctrl_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .ld    (ctrl_wr),
        .din   (bus_wdata),
        .ctrl_q(ctrl_q)
    );

    flc_drive_sel u_sel (
        .ctrl    (ctrl_q),
        .drv_sel (drv_sel),
        .drv_side(drv_side)
    );

    always_comb begin
        single_den = ctrl_q.single_den;
        host_nmi   = fdc_drq && ctrl_q.nmi_en;
    end
endmodule

// File: rtl/floppy_ctrl_latch_chk.sv
module floppy_ctrl_latch_chk
    import flc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_en,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic                bus_we,
    input logic                fdc_drq,
    input logic                fdc_cs,
    input logic [N_DRIVES-1:0] drv_sel,
    input logic [N_DRIVES-1:0] drv_side,
    input logic                single_den,
    input logic                host_nmi
);
    // R1
    cs_only_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        fdc_cs |-> (bus_en && bus_addr != CTRL_OFFSET));

    // R2
    hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we && bus_addr == CTRL_OFFSET) |=>
            ($stable(drv_sel) && $stable(drv_side) && $stable(single_den)));

    // R3
    one_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drv_sel));

    // R4
    side_on_selected_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_side & ~drv_sel) == '0);

    // R6
    nmi_needs_drq_chk: assert property (@(posedge clk) disable iff (rst)
        host_nmi |-> fdc_drq);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (drv_sel == '0 && drv_side == '0 && !single_den));
endmodule

bind floppy_ctrl_latch floppy_ctrl_latch_chk u_chk (.*);

// File: tb/floppy_ctrl_latch_tb_top.sv
module floppy_ctrl_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       bus_en;
    logic [7:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic       fdc_drq;
    logic       fdc_cs;
    logic [1:0] drv_sel;
    logic [1:0] drv_side;
    logic       single_den;
    logic       host_nmi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    floppy_ctrl_latch dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .fdc_drq(fdc_drq),
        .fdc_cs(fdc_cs), .drv_sel(drv_sel), .drv_side(drv_side),
        .single_den(single_den), .host_nmi(host_nmi)
    );

    typedef struct packed {
        logic       en;
        logic       we;
        logic       drq;
        logic [7:0] addr;
        logic [7:0] data;
        logic       x_cs;
        logic [1:0] x_sel;
        logic [1:0] x_side;
        logic       x_den;
        logic       x_nmi;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,1'b0,8'hFC,8'h02,1'b0,2'b01,2'b00,1'b0,1'b0}, // R3 drive 0
        '{1'b1,1'b1,1'b0,8'hFC,8'h03,1'b0,2'b01,2'b01,1'b0,1'b0}, // R4 side on drive 0
        '{1'b1,1'b1,1'b0,8'hFC,8'h05,1'b0,2'b10,2'b10,1'b0,1'b0}, // R4 side on drive 1
        '{1'b1,1'b1,1'b0,8'hFC,8'h07,1'b0,2'b10,2'b10,1'b0,1'b0}, // R3 both -> drive 1
        '{1'b1,1'b1,1'b1,8'hFC,8'h01,1'b0,2'b00,2'b00,1'b0,1'b0}, // R4 no drive, R6 masked
        '{1'b1,1'b1,1'b1,8'hFC,8'h10,1'b0,2'b00,2'b00,1'b0,1'b1}, // R6 enabled
        '{1'b1,1'b1,1'b0,8'hFC,8'h20,1'b0,2'b00,2'b00,1'b1,1'b0}, // R5 single density
        '{1'b1,1'b1,1'b0,8'hFC,8'hC8,1'b0,2'b00,2'b00,1'b0,1'b0}, // R7 spare bits
        '{1'b1,1'b0,1'b0,8'hFC,8'h07,1'b0,2'b00,2'b00,1'b0,1'b0}, // R2 read of FC
        '{1'b1,1'b1,1'b0,8'hF8,8'h07,1'b1,2'b00,2'b00,1'b0,1'b0}, // R1/R2 write F8
        '{1'b1,1'b0,1'b0,8'hFB,8'h07,1'b1,2'b00,2'b00,1'b0,1'b0}, // R1 read FB
        '{1'b0,1'b1,1'b0,8'hFC,8'h07,1'b0,2'b00,2'b00,1'b0,1'b0}, // R1/R2 not enabled
        '{1'b1,1'b1,1'b0,8'hFD,8'h07,1'b0,2'b00,2'b00,1'b0,1'b0}, // R1/R2 FD
        '{1'b1,1'b1,1'b0,8'hF7,8'h07,1'b0,2'b00,2'b00,1'b0,1'b0}, // R1/R2 F7
        '{1'b1,1'b1,1'b1,8'hFC,8'h16,1'b0,2'b10,2'b00,1'b0,1'b1}  // R3/R6 mix
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; bus_en = 1'b0; bus_addr = '0; bus_we = 1'b0;
        bus_wdata = '0; fdc_drq = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state, DRQ high
        chk("R8 sel", {6'd0, drv_sel}, 8'h00);
        chk("R8 side", {6'd0, drv_side}, 8'h00);
        chk("R8 den", {7'd0, single_den}, 8'h00);
        chk("R8 nmi", {7'd0, host_nmi}, 8'h00);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_en = VECS[i].en; bus_we = VECS[i].we; bus_addr = VECS[i].addr;
            bus_wdata = VECS[i].data; fdc_drq = VECS[i].drq;
            #1;
            chk($sformatf("R1 cs v%0d", i), {7'd0, fdc_cs}, {7'd0, VECS[i].x_cs});
            @(posedge clk);
            @(negedge clk);
            bus_en = 1'b0;
            #1;
            chk($sformatf("R2/R3 sel v%0d", i), {6'd0, drv_sel}, {6'd0, VECS[i].x_sel});
            chk($sformatf("R4 side v%0d", i), {6'd0, drv_side}, {6'd0, VECS[i].x_side});
            chk($sformatf("R5/R7 den v%0d", i), {7'd0, single_den}, {7'd0, VECS[i].x_den});
            chk($sformatf("R6 nmi v%0d", i), {7'd0, host_nmi}, {7'd0, VECS[i].x_nmi});
        end

        // R6: NMI falls in the same cycle DRQ falls, no clock needed
        fdc_drq = 1'b0;
        #1;
        chk("R6 nmi drop", {7'd0, host_nmi}, 8'h00);
        fdc_drq = 1'b1;
        #1;
        chk("R6 nmi rise", {7'd0, host_nmi}, 8'h01);

        // R8: mid-run reset clears a full control byte
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 8'hFC; bus_wdata = 8'h37;
        @(negedge clk);
        bus_en = 1'b0;
        #1;
        chk("R3 pre-reset sel", {6'd0, drv_sel}, 8'h02);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 sel after reset", {6'd0, drv_sel}, 8'h00);
        chk("R8 side after reset", {6'd0, drv_side}, 8'h00);
        chk("R8 den after reset", {7'd0, single_den}, 8'h00);
        chk("R8 nmi after reset", {7'd0, host_nmi}, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule